// File: doc/BRIEF.md
# Display Blanking and Dimming Controller

This block produces one drive-enable per character position of a multi-digit display. It combines four sources of blanking: an active-low external blank pin, a master-blank bit in an 8-bit control register, a per-digit keep-on attribute bit, and an extended-disable bit in the same register. The extended-disable bit decides whether the register and attribute sources count at all. Blanking acts only on the drive enables. The control register still takes writes and holds them while the display is dark.

The block also dims the display. A three-bit brightness code in the control register selects one of eight non-linear on-time ratios. The ratio is applied by a free-running frame counter. A new code is loaded only at a frame boundary, so a code change never produces a runt on-pulse. Setting extended-disable turns off internal dimming as well. Dimming can still be done externally by driving a pulse-width-modulated waveform onto the blank pin.

Top module: `disp_blank_ctrl`

## Requirements
- R1: With control bit 6 (extended-disable) at 1, every digit is enabled exactly when the synchronized blank pin is high. Master blank (bit 2) and the keep-on attribute bits have no effect.
- R2: With control bit 6 at 0, a digit whose keep-on bit is 0 is disabled whenever the synchronized blank pin is low or control bit 2 (master blank) is 1.
- R3: With control bit 6 at 0, a digit whose keep-on bit is 1 ignores both the blank pin and master blank. It follows only the internal dimming signal.
- R4: A write strobe loads the 8-bit write data into the control register on the next clock edge, whether or not the display is blanked. The register value appears on `ctrl_o`. Reset clears the register to 0x00.
- R5: Control bits 5:3 hold a brightness code. Codes 0 to 7 enable digits for 100, 60, 40, 27, 17, 10, 7 and 3 percent of each FRAME_TICKS-cycle frame. Within a frame the on-time comes first.
- R6: With control bit 6 at 1, internal dimming is off, and the brightness code does not reduce the on-time.
- R7: A newly written brightness code takes effect only at the start of the next frame. The frame in progress keeps the old code.
- R8: The blank pin passes through a two-flop synchronizer. A change on the pin reaches the enables after the second clock edge. Through reset the synchronizer holds the blanked state, so all enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 8 | Control register write data |
| keep_on_i | input | NUM_DIGITS | Per-digit keep-on (blank override) attribute bits |
| blank_ni | input | 1 | External blank pin, active low, asynchronous |
| ctrl_o | output | 8 | Current control register contents |
| digit_en_o | output | NUM_DIGITS | Per-digit driver enable |

## Verification
The bench builds the block with NUM_DIGITS = 4 and the default FRAME_TICKS = 100. With a 100-tick frame, each duty percentage maps to a whole number of on-cycles, so the on-cycles in any frame-long window can be counted exactly for all eight codes. Four digits are enough to put keep-on and normal digits side by side in one vector. A frame this short also lets the bench find a frame boundary by watching an output edge, so it can show that a mid-frame code change waits for that boundary.

// File: rtl/disp_blank_pkg.sv
package disp_blank_pkg;
  localparam int CTRL_W  = 8;
  localparam int EFD_BIT = 6;
  localparam int MB_BIT  = 2;
  localparam int BRT_LSB = 3;
  localparam int BRT_W   = 3;

  // on-time in percent per brightness code, 0 = brightest
  function automatic int duty_pct(input logic [BRT_W-1:0] code);
    case (code)
      3'd0:    return 100;
      3'd1:    return 60;
      3'd2:    return 40;
      3'd3:    return 27;
      3'd4:    return 17;
      3'd5:    return 10;
      3'd6:    return 7;
      default: return 3;
    endcase
  endfunction
endpackage

// File: rtl/disp_blank_sync.sv
module disp_blank_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] stage_q;

  // resets to 0: display stays dark until the pin is sampled
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= '0;
    else         stage_q <= {stage_q[STAGES-2:0], async_i};
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/disp_ctrl_reg.sv
module disp_ctrl_reg
  import disp_blank_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output logic [CTRL_W-1:0] ctrl_o
);
  logic [CTRL_W-1:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctrl_q <= '0;
    else if (we_i) ctrl_q <= wdata_i;
  end

  assign ctrl_o = ctrl_q;

  // R4
  ctrl_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> ctrl_q == $past(wdata_i));
endmodule

// File: rtl/disp_pwm_dimmer.sv
module disp_pwm_dimmer
  import disp_blank_pkg::*;
#(
  parameter int FRAME_TICKS = 100
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [BRT_W-1:0] code_i,
  input  logic             bypass_i,
  output logic             on_o
);
  localparam int CNT_W = $clog2(FRAME_TICKS);
  localparam int THR_W = CNT_W + 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_TICKS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [BRT_W-1:0] code_q;
  logic [THR_W-1:0] thr;
  logic             frame_end;

  assign frame_end = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      code_q <= '0;
    end else if (frame_end) begin
      cnt_q  <= '0;
      code_q <= code_i;  // new code only at frame start
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign thr  = THR_W'((duty_pct(code_q) * FRAME_TICKS) / 100);
  assign on_o = bypass_i | ({1'b0, cnt_q} < thr);

  // R5
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);

  // R7
  code_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |-> $stable(code_q));

  // R6
  bypass_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bypass_i |-> on_o);
endmodule

// File: rtl/disp_blank_ctrl.sv
module disp_blank_ctrl
  import disp_blank_pkg::*;
#(
  parameter int NUM_DIGITS  = 8,
  parameter int FRAME_TICKS = 100,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  ctrl_we_i,
  input  logic [CTRL_W-1:0]     ctrl_wdata_i,
  input  logic [NUM_DIGITS-1:0] keep_on_i,
  input  logic                  blank_ni,
  output logic [CTRL_W-1:0]     ctrl_o,
  output logic [NUM_DIGITS-1:0] digit_en_o
);
  logic [CTRL_W-1:0] ctrl_q;
  logic              blank_s;
  logic              pwm_on;
  logic              efd;
  logic              mb;

  disp_ctrl_reg u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ctrl_we_i),
    .wdata_i (ctrl_wdata_i),
    .ctrl_o  (ctrl_q)
  );

  disp_blank_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (blank_ni),
    .sync_o  (blank_s)
  );

  assign efd = ctrl_q[EFD_BIT];
  assign mb  = ctrl_q[MB_BIT];

  disp_pwm_dimmer #(.FRAME_TICKS(FRAME_TICKS)) u_pwm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .code_i   (ctrl_q[BRT_LSB +: BRT_W]),
    .bypass_i (efd),
    .on_o     (pwm_on)
  );

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_digit
    logic lit;
    always_comb begin
      if (efd) lit = blank_s;
      else     lit = keep_on_i[i] | (blank_s & ~mb);
    end
    assign digit_en_o[i] = lit & pwm_on;

    // R3
    keep_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!efd && keep_on_i[i] && pwm_on) |-> digit_en_o[i]);
  end

  assign ctrl_o = ctrl_q;

  // R1
  efd_blank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (efd && !blank_s) |-> (digit_en_o == '0));

  // R2
  master_blank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!efd && mb) |-> ((digit_en_o & ~keep_on_i) == '0));
endmodule

// File: tb/disp_blank_ctrl_bench.sv
module disp_blank_ctrl_bench;
  localparam int ND = 4;
  localparam int FT = 100;

  logic          clk_i = 0;
  logic          rst_ni = 0;
  logic          ctrl_we_i = 0;
  logic [7:0]    ctrl_wdata_i = '0;
  logic [ND-1:0] keep_on_i = '0;
  logic          blank_ni = 1;
  logic [7:0]    ctrl_o;
  logic [ND-1:0] digit_en_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  disp_blank_ctrl #(.NUM_DIGITS(ND), .FRAME_TICKS(FT)) u_disp_blank_ctrl (
    .clk_i, .rst_ni, .ctrl_we_i, .ctrl_wdata_i, .keep_on_i, .blank_ni,
    .ctrl_o, .digit_en_o
  );

  // {efd, mb, blank_n, keep[3:0], expected[3:0]}, brightness code 0
  localparam logic [10:0] VEC [10] = '{
    {3'b001, 4'b0000, 4'b1111},  // R2 all on
    {3'b000, 4'b0000, 4'b0000},  // R2 pin blank
    {3'b000, 4'b0101, 4'b0101},  // R3 keep-on under pin blank
    {3'b011, 4'b0000, 4'b0000},  // R2 master blank
    {3'b011, 4'b1001, 4'b1001},  // R3 keep-on under master blank
    {3'b010, 4'b0010, 4'b0010},  // R3 both blanks
    {3'b100, 4'b1111, 4'b0000},  // R1 keep ignored
    {3'b111, 4'b0000, 4'b1111},  // R1 master ignored
    {3'b101, 4'b1010, 4'b1111},  // R1
    {3'b110, 4'b0110, 4'b0000}   // R1
  };

  localparam int PCT [8] = '{100, 60, 40, 27, 17, 10, 7, 3};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk_i);
    ctrl_we_i = 1; ctrl_wdata_i = d;
    @(negedge clk_i);
    ctrl_we_i = 0;
  endtask

  task automatic wait_cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk_i);
  endtask

  task automatic count_on(output int n);
    n = 0;
    for (int k = 0; k < FT; k++) begin
      @(negedge clk_i);
      if (digit_en_o[0]) n++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n;
    // reset state: R4, R8
    wait_cyc(3);
    chk("R4 reset ctrl", 32'(ctrl_o), 32'h00);
    chk("R8 reset enables", 32'(digit_en_o), 32'h0);
    @(negedge clk_i) rst_ni = 1;
    wait_cyc(4);
    chk("R8 on after sync", 32'(digit_en_o), 32'hF);

    // truth table walk
    foreach (VEC[v]) begin
      wr({1'b0, VEC[v][10], 3'b000, VEC[v][9], 2'b00});
      keep_on_i = VEC[v][7:4];
      blank_ni  = VEC[v][8];
      wait_cyc(4);
      chk($sformatf("R1/R2/R3 vector %0d", v), 32'(digit_en_o), 32'(VEC[v][3:0]));
    end

    // R4: write while blanked is kept
    keep_on_i = '0; blank_ni = 0;
    wr(8'h00);
    wait_cyc(3);
    wr(8'hA9);
    chk("R4 write while blanked", 32'(ctrl_o), 32'hA9);
    chk("R4 display still blanked", 32'(digit_en_o), 32'h0);
    wr(8'h00);

    // R8: two-edge latency
    blank_ni = 1;
    wait_cyc(4);
    @(negedge clk_i) blank_ni = 0;
    @(negedge clk_i);
    chk("R8 one edge still on", 32'(digit_en_o), 32'hF);
    @(negedge clk_i);
    chk("R8 two edges blanked", 32'(digit_en_o), 32'h0);
    blank_ni = 1;
    wait_cyc(3);

    // R5: duty per code
    for (int c = 0; c < 8; c++) begin
      wr(8'(c << 3));
      wait_cyc(2 * FT);
      count_on(n);
      chk($sformatf("R5 duty code %0d", c), 32'(n), 32'(PCT[c] * FT / 100));
    end

    // R6: extended-disable overrides dimming
    wr(8'h78);
    wait_cyc(2 * FT);
    count_on(n);
    chk("R6 no dimming with efd", 32'(n), 32'(FT));

    // R7: mid-frame change waits for frame end
    wr(8'h08);
    wait_cyc(2 * FT);
    while (!digit_en_o[0]) @(negedge clk_i);
    while (digit_en_o[0]) @(negedge clk_i);
    // now at tick 60 of a 60% frame
    wr(8'h00);
    wait_cyc(28);
    chk("R7 old code held to frame end", 32'(digit_en_o[0]), 32'h0);
    wait_cyc(20);
    chk("R7 new code after boundary", 32'(digit_en_o[0]), 32'h1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule